// File: doc/BRIEF.md
# Flow-Controlled FIFO Link Endpoint

This block is one end of a point-to-point word link that the host sees as a pair of FIFOs. Words the host pushes into the local send queue leave on the outgoing line and, at the far endpoint, land in that endpoint's receive queue, where the far host pops them. The line side is a word-wide bus with a valid strobe in each direction, standing in for an external serializer. Two instances wired back to back form a bidirectional virtual FIFO.

Pacing is automatic. Each line word has an extra top bit that marks it as control or data. When the local receive queue fills past an upper mark, the endpoint sends a "pause" control word to the far end. Once the queue has drained below a lower mark, it sends a "resume" word. A received pause word stops the local transmitter after at most one more data word, and a resume word restarts it. The host never sees control words and takes no part in the exchange.

Top module: `fifo_link_endpoint`

## Requirements
- R1: After reset the receive queue is empty (`rd_empty`=1), the send queue is not full (`wr_full`=0) and `tx_valid`=0. Transmission is permitted, so a word written after reset goes out on the line as a data word without any resume word having arrived.
- R2: For two endpoints cross-connected on their line ports, every word written at one host port is read at the far host port once, unchanged and in order.
- R3: The line word is DATA_W+1 bits wide. Bit DATA_W=1 marks control and bit DATA_W=0 marks data. The pause word is 1 in bit DATA_W with bit 0 = 0, so it is 0x100 for DATA_W=8. It is sent exactly once when receive occupancy first exceeds HI_MARK.
- R4: The resume word is 1 in bit DATA_W with bit 0 = 1, so it is 0x101 for DATA_W=8. After a pause word it is sent exactly once, when occupancy falls below LO_MARK. It is not sent while occupancy stays at or above LO_MARK.
- R5: A received control word is never stored in the receive queue.
- R6: Once a pause word has been received, at most one more data word leaves on `tx_word`. No further data word leaves until a resume word arrives.
- R7: A received resume word restarts transmission, and the queued words then leave in order.
- R8: A pending control word takes the outgoing line ahead of a data word that is ready to send.
- R9: `wr_full` rises when the send queue holds DEPTH words, and a write while full is dropped. A read while `rd_empty`=1 is ignored and does not disturb later data.
- R10: Under arbitrary host read back-pressure, the receive queue never overflows with the default marks. Each mark crossing at the far end produces pause traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host push into send queue |
| wr_data | input | DATA_W | Word to push |
| wr_full | output | 1 | Send queue full |
| rd_en | input | 1 | Host pop from receive queue |
| rd_data | output | DATA_W | Head of receive queue (valid while not empty) |
| rd_empty | output | 1 | Receive queue empty |
| tx_valid | output | 1 | Outgoing line word valid |
| tx_word | output | DATA_W+1 | Outgoing line word, top bit = control flag |
| rx_valid | input | 1 | Incoming line word valid |
| rx_word | input | DATA_W+1 | Incoming line word, top bit = control flag |

## Verification
The bench pushes the receive queue one word past the upper mark and then drains it one word at a time across the lower mark. An endpoint with an off-by-one threshold, or without hysteresis, would send its pause or resume word early, late, or more than once. It also makes a control word and a data word compete for the same cycle, which exposes an arbiter that lets data win. It then fills the send queue while the far end is paused, so a lost or duplicated word, or an overwrite on a full write, shows up. Finally, a long cross-connected stream with random read stalls would expose any overflow caused by an in-flight allowance that is too small.

// File: rtl/flink_pkg.sv
package flink_pkg;
   // what the outgoing line carries in a given cycle
   typedef enum logic [1:0] {
      TX_IDLE = 2'd0,
      TX_CTRL = 2'd1,
      TX_DATA = 2'd2
   } tx_sel_e;

   // words that may still arrive after a pause decision
   localparam int INFLIGHT_SLACK = 4;

   function automatic int occ_bits(input int depth);
      return $clog2(depth + 1);
   endfunction
endpackage

// File: rtl/flink_fifo.sv
module flink_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 16
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   push,
   input  logic [WIDTH-1:0]                       din,
   input  logic                                   pop,
   output logic [WIDTH-1:0]                       dout,
   output logic [flink_pkg::occ_bits(DEPTH)-1:0]  count
);
   localparam int  AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int  CW   = flink_pkg::occ_bits(DEPTH);
   localparam bit  POW2 = (DEPTH & (DEPTH - 1)) == 0;

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wp, rp, wp_inc, rp_inc;
   logic             do_push, do_pop;

   assign do_push = push && (count != CW'(DEPTH));
   assign do_pop  = pop  && (count != '0);
   assign dout    = mem[rp];

   generate
      if (POW2) begin : g_wrap_pow2
         assign wp_inc = wp + 1'b1;
         assign rp_inc = rp + 1'b1;
      end else begin : g_wrap_cmp
         assign wp_inc = (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
         assign rp_inc = (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (do_push) wp <= wp_inc;
         if (do_pop)  rp <= rp_inc;
         case ({do_push, do_pop})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/flink_flow.sv
module flink_flow #(
   parameter int CW      = 5,
   parameter int HI_MARK = 8,
   parameter int LO_MARK = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] occ,
   output logic          ctrl_req,
   output logic          ctrl_xon,
   input  logic          ctrl_taken
);
   // set once a pause word has gone out, cleared by the resume word
   logic paused_far;

   assign ctrl_xon = paused_far;
   assign ctrl_req = paused_far ? (occ < CW'(LO_MARK)) : (occ > CW'(HI_MARK));

   always_ff @(posedge clk) begin
      if (!rst_n)          paused_far <= 1'b0;
      else if (ctrl_taken) paused_far <= !paused_far;
   end
endmodule

// File: rtl/flink_rx.sv
module flink_rx #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rx_valid,
   input  logic [W:0]   rx_word,
   output logic         data_push,
   output logic [W-1:0] data,
   output logic         peer_ok
);
   logic is_ctrl;

   assign is_ctrl   = rx_valid && rx_word[W];
   assign data_push = rx_valid && !rx_word[W];
   assign data      = rx_word[W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n)       peer_ok <= 1'b1;
      else if (is_ctrl) peer_ok <= rx_word[0];
   end
endmodule

// File: rtl/flink_tx.sv
module flink_tx #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ctrl_req,
   input  logic         ctrl_xon,
   input  logic         peer_ok,
   input  logic         sq_empty,
   input  logic [W-1:0] sq_data,
   output logic         sq_pop,
   output logic         ctrl_taken,
   output logic         tx_valid,
   output logic [W:0]   tx_word
);
   import flink_pkg::*;

   tx_sel_e    sel;
   logic [W:0] ctrl_word;

   always_comb begin
      if (ctrl_req)                 sel = TX_CTRL;
      else if (peer_ok && !sq_empty) sel = TX_DATA;
      else                          sel = TX_IDLE;
   end

   always_comb begin
      ctrl_word    = '0;
      ctrl_word[W] = 1'b1;
      ctrl_word[0] = ctrl_xon;
   end

   assign sq_pop     = (sel == TX_DATA);
   assign ctrl_taken = (sel == TX_CTRL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_valid <= 1'b0;
         tx_word  <= '0;
      end else begin
         tx_valid <= (sel != TX_IDLE);
         case (sel)
            TX_CTRL: tx_word <= ctrl_word;
            TX_DATA: tx_word <= {1'b0, sq_data};
            default: tx_word <= tx_word;
         endcase
      end
   end
endmodule

// File: rtl/fifo_link_endpoint.sv
module fifo_link_endpoint #(
   parameter int DATA_W  = 8,
   parameter int DEPTH   = 16,
   parameter int HI_MARK = DEPTH / 2,
   parameter int LO_MARK = DEPTH / 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_full,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_empty,
   output logic              tx_valid,
   output logic [DATA_W:0]   tx_word,
   input  logic              rx_valid,
   input  logic [DATA_W:0]   rx_word
);
   localparam int CW = flink_pkg::occ_bits(DEPTH);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("DATA_W must be at least 2");
      end
      if (LO_MARK < 1 || LO_MARK >= HI_MARK) begin : g_bad_marks
         $error("marks need 1 <= LO_MARK < HI_MARK");
      end
      if (HI_MARK + flink_pkg::INFLIGHT_SLACK > DEPTH) begin : g_bad_slack
         $error("DEPTH leaves too little room above HI_MARK");
      end
   endgenerate

   logic [CW-1:0]     sq_cnt, rx_cnt;
   logic [DATA_W-1:0] sq_data, rx_data;
   logic              sq_pop, rx_push, peer_ok;
   logic              ctrl_req, ctrl_xon, ctrl_taken;

   assign wr_full  = (sq_cnt == CW'(DEPTH));
   assign rd_empty = (rx_cnt == '0);

   flink_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_send_q (
      .clk(clk), .rst_n(rst_n),
      .push(wr_en), .din(wr_data),
      .pop(sq_pop), .dout(sq_data), .count(sq_cnt)
   );

   flink_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_recv_q (
      .clk(clk), .rst_n(rst_n),
      .push(rx_push), .din(rx_data),
      .pop(rd_en), .dout(rd_data), .count(rx_cnt)
   );

   flink_rx #(.W(DATA_W)) u_rx (
      .clk(clk), .rst_n(rst_n),
      .rx_valid(rx_valid), .rx_word(rx_word),
      .data_push(rx_push), .data(rx_data), .peer_ok(peer_ok)
   );

   flink_flow #(.CW(CW), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK)) u_flow (
      .clk(clk), .rst_n(rst_n), .occ(rx_cnt),
      .ctrl_req(ctrl_req), .ctrl_xon(ctrl_xon), .ctrl_taken(ctrl_taken)
   );

   flink_tx #(.W(DATA_W)) u_tx (
      .clk(clk), .rst_n(rst_n),
      .ctrl_req(ctrl_req), .ctrl_xon(ctrl_xon), .peer_ok(peer_ok),
      .sq_empty(sq_cnt == '0), .sq_data(sq_data),
      .sq_pop(sq_pop), .ctrl_taken(ctrl_taken),
      .tx_valid(tx_valid), .tx_word(tx_word)
   );
endmodule

// File: rtl/flink_link_chk.sv
module flink_link_chk #(
   parameter int DATA_W  = 8,
   parameter int DEPTH   = 16,
   parameter int HI_MARK = 8,
   parameter int LO_MARK = 4,
   parameter int CW      = 5
) (
   input logic            clk,
   input logic            rst_n,
   input logic            rx_valid,
   input logic [DATA_W:0] rx_word,
   input logic            tx_valid,
   input logic [DATA_W:0] tx_word,
   input logic [CW-1:0]   rx_cnt,
   input logic            rd_en,
   input logic            ctrl_req
);
   logic rx_ctrl, rx_data_w, rx_pause, rx_resume, tx_pause, tx_resume, tx_data_w;

   assign rx_ctrl   = rx_valid && rx_word[DATA_W];
   assign rx_data_w = rx_valid && !rx_word[DATA_W];
   assign rx_pause  = rx_ctrl && !rx_word[0];
   assign rx_resume = rx_ctrl && rx_word[0];
   assign tx_pause  = tx_valid && tx_word[DATA_W] && !tx_word[0];
   assign tx_resume = tx_valid && tx_word[DATA_W] && tx_word[0];
   assign tx_data_w = tx_valid && !tx_word[DATA_W];

   // R10
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_data_w |-> rx_cnt < CW'(DEPTH));

   // R5
   ctrl_not_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_ctrl && !rd_en) |=> rx_cnt == $past(rx_cnt));

   // R3
   pause_above_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_pause |-> $past(rx_cnt) > CW'(HI_MARK));

   // R4
   resume_below_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_resume |-> $past(rx_cnt) < CW'(LO_MARK));

   // R6
   pause_stops_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_pause ##1 !rx_resume) |=> !tx_data_w);

   // R8
   ctrl_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_req |=> (tx_valid && tx_word[DATA_W]));
endmodule

bind fifo_link_endpoint flink_link_chk #(
   .DATA_W(DATA_W), .DEPTH(DEPTH), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK), .CW(CW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_word(rx_word),
   .tx_valid(tx_valid), .tx_word(tx_word), .rx_cnt(rx_cnt),
   .rd_en(rd_en), .ctrl_req(ctrl_req)
);

// File: tb/fifo_link_endpoint_tb.sv
`timescale 1ns/1ps
module fifo_link_endpoint_tb;
   localparam int W = 8, D = 16, HI = 8, LO = 4, NWORDS = 300;
   localparam logic [W:0] PAUSE = 9'h100, RESUME = 9'h101;

   logic clk = 1'b0, rst_n = 1'b0;
   always #2.5 clk = ~clk;

   // cross-connected pair: u_dut -> u_peer
   logic a_wr_en = 0, a_rd_en = 0, a_full, a_empty, a_txv;
   logic [W-1:0] a_wr_data = 0, a_rd_data;
   logic [W:0] a_txw;
   logic b_wr_en = 0, b_rd_en = 0, b_full, b_empty, b_txv;
   logic [W-1:0] b_wr_data = 0, b_rd_data;
   logic [W:0] b_txw;
   // standalone endpoint with a bench-driven line input
   logic s_wr_en = 0, s_rd_en = 0, s_full, s_empty, s_txv, s_rxv = 0;
   logic [W-1:0] s_wr_data = 0, s_rd_data;
   logic [W:0] s_txw, s_rxw = 0;

   fifo_link_endpoint #(.DATA_W(W), .DEPTH(D)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(a_wr_en), .wr_data(a_wr_data), .wr_full(a_full),
      .rd_en(a_rd_en), .rd_data(a_rd_data), .rd_empty(a_empty),
      .tx_valid(a_txv), .tx_word(a_txw), .rx_valid(b_txv), .rx_word(b_txw));
   fifo_link_endpoint #(.DATA_W(W), .DEPTH(D)) u_peer (
      .clk(clk), .rst_n(rst_n), .wr_en(b_wr_en), .wr_data(b_wr_data), .wr_full(b_full),
      .rd_en(b_rd_en), .rd_data(b_rd_data), .rd_empty(b_empty),
      .tx_valid(b_txv), .tx_word(b_txw), .rx_valid(a_txv), .rx_word(a_txw));
   fifo_link_endpoint #(.DATA_W(W), .DEPTH(D)) u_solo (
      .clk(clk), .rst_n(rst_n), .wr_en(s_wr_en), .wr_data(s_wr_data), .wr_full(s_full),
      .rd_en(s_rd_en), .rd_data(s_rd_data), .rd_empty(s_empty),
      .tx_valid(s_txv), .tx_word(s_txw), .rx_valid(s_rxv), .rx_word(s_rxw));

   int errors = 0, checks = 0;
   int n_pause = 0, n_resume = 0, n_data = 0, b_pause = 0;
   logic [W-1:0] last_data = 0;
   logic [W:0] txlog [$];
   logic [W-1:0] sb [$];

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clear_log();
      txlog.delete(); n_pause = 0; n_resume = 0; n_data = 0;
   endtask

   always @(negedge clk) begin
      if (rst_n && s_txv) begin
         txlog.push_back(s_txw);
         if (s_txw == PAUSE) n_pause++;
         else if (s_txw == RESUME) n_resume++;
         else if (!s_txw[W]) begin n_data++; last_data = s_txw[W-1:0]; end
      end
      if (rst_n && b_txv && b_txw == PAUSE) b_pause++;
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic line_in(input logic [W:0] w);
      @(negedge clk); s_rxv = 1; s_rxw = w;
      @(negedge clk); s_rxv = 0;
   endtask

   task automatic line_burst(input logic [W:0] w);   // leaves the strobe for the caller
      @(negedge clk); s_rxv = 1; s_rxw = w;
   endtask

   task automatic solo_write(input logic [W-1:0] v);
      @(negedge clk); s_wr_en = 1; s_wr_data = v;
      @(negedge clk); s_wr_en = 0;
   endtask

   task automatic solo_read(input logic [W-1:0] exp, input string req);
      @(negedge clk);
      check(!s_empty && s_rd_data == exp, req, s_rd_data, exp);
      s_rd_en = 1;
      @(negedge clk); s_rd_en = 0;
   endtask

   task automatic drive_stream();
      for (int i = 0; i < NWORDS; i++) begin
         @(negedge clk);
         while (a_full) begin a_wr_en = 0; @(negedge clk); end
         a_wr_en = 1; a_wr_data = W'((i * 37 + 5) & 8'hff);
         sb.push_back(a_wr_data);
      end
      @(negedge clk); a_wr_en = 0;
   endtask

   task automatic monitor_stream();
      int got = 0;
      while (got < NWORDS) begin
         @(negedge clk);
         b_rd_en = 0;
         if (!b_empty && ($urandom % 4 == 0)) begin
            if (sb.size() == 0) check(0, "R2 unexpected word", b_rd_data, 0);
            else begin
               check(b_rd_data == sb[0], "R2 stream order", b_rd_data, sb[0]);
               void'(sb.pop_front());
            end
            b_rd_en = 1;
            got++;
         end
      end
      @(negedge clk); b_rd_en = 0;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      idle(5);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      check(s_empty == 1, "R1 empty", s_empty, 1);
      check(s_full == 0, "R1 full", s_full, 0);
      check(s_txv == 0, "R1 tx_valid", s_txv, 0);
      clear_log();
      solo_write(8'h33);
      idle(4);
      check(n_data == 1 && last_data == 8'h33, "R1 sends after reset", last_data, 8'h33);

      // R5 control words are not stored
      line_in(RESUME); line_in(RESUME);
      idle(3);
      check(s_empty == 1, "R5 ctrl not stored", s_empty, 1);

      // R3 pause exactly once past the upper mark
      clear_log();
      for (int i = 0; i < HI; i++) line_in({1'b0, W'(8'h10 + i)});
      idle(5);
      check(n_pause == 0, "R3 no pause at mark", n_pause, 0);
      line_in({1'b0, W'(8'h10 + HI)});
      idle(5);
      check(n_pause == 1, "R3 pause past mark", n_pause, 1);
      line_in({1'b0, 8'h19}); line_in({1'b0, 8'h1a});
      idle(5);
      check(n_pause == 1, "R3 pause sent once", n_pause, 1);

      // R4 resume below the lower mark, with hysteresis
      for (int i = 0; i < HI + 3 - LO; i++) solo_read(W'(8'h10 + i), "R4 data order");
      idle(4);
      check(n_resume == 0, "R4 no resume at lower mark", n_resume, 0);
      solo_read(W'(8'h10 + HI + 3 - LO), "R4 data order");
      idle(4);
      check(n_resume == 1, "R4 resume below mark", n_resume, 1);
      for (int i = HI + 4 - LO; i < HI + 3; i++) solo_read(W'(8'h10 + i), "R4 data order");
      idle(4);
      check(n_resume == 1 && n_pause == 1, "R4 single resume", n_resume, 1);

      // R6 pause stops transmission
      line_in(PAUSE);
      clear_log();
      for (int i = 0; i < 3; i++) solo_write(W'(8'h61 + i));
      idle(10);
      check(n_data == 0, "R6 no data while paused", n_data, 0);
      // R7 resume restarts transmission
      line_in(RESUME);
      idle(8);
      check(n_data == 3 && last_data == 8'h63, "R7 resumed data", last_data, 8'h63);

      // R8 control beats ready data
      line_in(PAUSE);
      for (int i = 0; i < 3; i++) solo_write(W'(8'h41 + i));
      for (int i = 0; i < HI; i++) line_in({1'b0, W'(8'h20 + i)});
      idle(3);
      clear_log();
      line_burst(RESUME);
      line_burst({1'b0, W'(8'h20 + HI)});
      @(negedge clk); s_rxv = 0;
      idle(8);
      check(txlog.size() == 4, "R8 log length", txlog.size(), 4);
      if (txlog.size() == 4) begin
         check(txlog[0] == {1'b0, 8'h41}, "R8 first word", txlog[0], {1'b0, 8'h41});
         check(txlog[1] == PAUSE, "R8 ctrl before data", txlog[1], PAUSE);
         check(txlog[2] == {1'b0, 8'h42}, "R8 data after ctrl", txlog[2], {1'b0, 8'h42});
      end
      for (int i = 0; i <= HI; i++) solo_read(W'(8'h20 + i), "R8 drain order");
      idle(4);

      // R9 full and dropped write
      line_in(PAUSE);
      for (int i = 0; i < D; i++) solo_write(W'(8'h80 + i));
      @(negedge clk);
      check(s_full == 1, "R9 full at depth", s_full, 1);
      solo_write(8'hee);
      clear_log();
      line_in(RESUME);
      idle(D + 6);
      check(n_data == D, "R9 word count", n_data, D);
      check(last_data == W'(8'h80 + D - 1), "R9 write while full dropped", last_data, 8'h80 + D - 1);
      check(s_full == 0, "R9 full clears", s_full, 0);

      // R9 read while empty ignored
      @(negedge clk); s_rd_en = 1;
      idle(2);
      s_rd_en = 0;
      line_in({1'b0, 8'h5a});
      solo_read(8'h5a, "R9 empty read ignored");
      idle(2);
      check(s_empty == 1, "R9 empty after read", s_empty, 1);

      // R2 / R10 stream through the cross-connected pair
      fork
         drive_stream();
         monitor_stream();
      join
      idle(4);
      check(sb.size() == 0, "R2 all delivered", sb.size(), 0);
      check(b_empty == 1, "R2 no extra words", b_empty, 1);
      check(b_pause > 0, "R10 pause traffic under back-pressure", b_pause, 1);
      finish_run();
   end
endmodule